// File: doc/BRIEF.md
# Translation insert field checker

This block sits in front of a translation buffer and decides whether the values feeding an insert are legal. It holds three kinds of architectural state: a translation attribute register (page size and protection key), a fault address register (the virtual address being mapped) and eight region registers (region identifiers). Software writes these through one write port. A separate insert port carries a 64-bit translation word and a flag choosing the instruction or data buffer.

Every write or insert is answered one clock later with a single-cycle response: accept, reserved-field fault, or unimplemented-address fault. An accepted insert also yields a decoded entry. This entry combines the translation word fields, the attribute register's page size and key, the page number part of the fault address, and the region identifier chosen by the top three address bits. The parameter `CHECK_ON_INSERT` decides when the attribute and address registers are validated. With 0 they are checked as they are written. With 1 any value is stored and the check runs on each insert. A translation word whose present bit is clear waives most checks.

Top module: `xlat_insert_checker`

## Requirements
- R1: While reset is active and after it, `rsp_valid` and `ent_valid` are low. All registers reset to zero, so an insert before any write shows key, page number and region identifier of zero.
- R2: A request sampled on a clock edge produces exactly one response cycle after that edge. The response code is 0 for accept, 1 for a reserved-field fault and 2 for an unimplemented-address fault, and no cycle without a request produces a response. A write with `wr_sel` = 3 is accepted and changes nothing.
- R3: When bit 0 (present) of the translation word is 0, no other bit of the word causes a fault.
- R4: On a present insert, a one in word bit 1, bit 50 or bit 51, or a memory attribute (bits 4:2) outside `MA_OK_MASK`, gives code 1.
- R5: An accepted insert decodes the translation word as follows: deferral flag bit 52, physical page 49:12, rights 11:9, privilege 8:7, dirty 6, accessed 5, memory attribute 4:2 and present bit 0, with bits 63:53 ignored. The entry adds page size (attribute bits 7:2), key (attribute bits 31:8) and virtual page (address bits 63:12). It also adds the region identifier from bits 31:8 of the region register indexed by address bits 63:61, and the buffer select.
- R6: The attribute value is faulty, code 1, if bits 1:0 or 63:32 are nonzero or its page size is outside `PS_OK_MASK`. With `CHECK_ON_INSERT`=0 the check is made on the write; with 1 it is made on the insert.
- R7: With `CHECK_ON_INSERT`=1 and a not-present word, attribute bits 63:32 and 31:8 are ignored. Bits 1:0 and the page size are still checked.
- R8: A region register write with bit 1 set or any bit of 63:32 set gives code 1.
- R9: An address is unimplemented when bits 60 down to `VA_BITS` are not all equal to bit `VA_BITS`-1. This gives code 2, on the address write when `CHECK_ON_INSERT`=0 and on the insert when it is 1.
- R10: When an insert has both a reserved-field and an unimplemented-address violation, the code is 1.
- R11: A faulting operation changes no register and raises no `ent_valid`.
- R12: When `wr_valid` and `ins_valid` are high together, the insert is served and the write is dropped without a response.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write request |
| wr_sel | input | 2 | Target: 0 attribute, 1 address, 2 region, 3 none |
| wr_rgn | input | 3 | Region register index |
| wr_data | input | 64 | Write value |
| ins_valid | input | 1 | Insert request |
| ins_dside | input | 1 | 1 selects the data buffer, 0 the instruction buffer |
| ins_word | input | 64 | Translation word |
| rsp_valid | output | 1 | Response pulse |
| rsp_code | output | 2 | 0 accept, 1 reserved field, 2 unimplemented address |
| rsp_ins | output | 1 | Response belongs to an insert |
| ent_valid | output | 1 | Decoded entry valid |
| ent_dside | output | 1 | Buffer select |
| ent_present | output | 1 | Present bit |
| ent_defer | output | 1 | Deferral flag |
| ent_ppn | output | 38 | Physical page number |
| ent_rights | output | 3 | Access rights |
| ent_priv | output | 2 | Privilege level |
| ent_dirty | output | 1 | Dirty bit |
| ent_acc | output | 1 | Accessed bit |
| ent_memattr | output | 3 | Memory attribute |
| ent_pgsz | output | 6 | Page size |
| ent_pkey | output | 24 | Protection key |
| ent_vpn | output | 52 | Virtual page number |
| ent_rid | output | 24 | Region identifier |

## Verification
The bench builds two copies side by side from one stimulus stream. One has `CHECK_ON_INSERT`=0 and the other 1, both with `VA_BITS`=51 and the default legal page-size and memory-attribute masks. The 51-bit address width puts both sign-extension polarities and the unimplemented band at bits 60:51 within a few directed vectors. Running both modes together shows the same bad attribute or address value faulting on the write in one copy and on the later insert in the other. It also shows the not-present waiver of attribute bits 63:32, which only the late-check copy has.

// File: rtl/xic_pkg.sv
package xic_pkg;
  localparam int WORD_W = 64;
  localparam int PPN_W  = 38;
  localparam int KEY_W  = 24;
  localparam int VPN_W  = 52;
  localparam int RID_W  = 24;
  localparam int VRN_W  = 3;
  localparam int NRGN   = 1 << VRN_W;

  typedef enum logic [1:0] {
    RSP_OK     = 2'd0,
    RSP_RSVD   = 2'd1,
    RSP_UNIMPL = 2'd2
  } rsp_code_e;

  typedef enum logic [1:0] {
    SEL_ATTR = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_RGN  = 2'd2,
    SEL_NONE = 2'd3
  } wr_sel_e;

  typedef struct packed {
    logic             dside;
    logic             present;
    logic             defer;
    logic [PPN_W-1:0] ppn;
    logic [2:0]       rights;
    logic [1:0]       priv;
    logic             dirty;
    logic             acc;
    logic [2:0]       memattr;
    logic [5:0]       pgsz;
    logic [KEY_W-1:0] pkey;
    logic [VPN_W-1:0] vpn;
    logic [RID_W-1:0] rid;
  } entry_t;
endpackage

// File: rtl/xic_word_chk.sv
module xic_word_chk
  import xic_pkg::*;
#(
  parameter logic [7:0] MA_OK_MASK = 8'hF1
) (
  input  logic [WORD_W-1:0] word,
  output logic              bad,
  output logic              present,
  output logic              defer,
  output logic [PPN_W-1:0]  ppn,
  output logic [2:0]        rights,
  output logic [1:0]        priv,
  output logic              dirty,
  output logic              acc,
  output logic [2:0]        memattr
);
  logic unused_ign;

  assign present = word[0];
  assign memattr = word[4:2];
  assign acc     = word[5];
  assign dirty   = word[6];
  assign priv    = word[8:7];
  assign rights  = word[11:9];
  assign ppn     = word[49:12];
  assign defer   = word[52];

  // reserved encodings only matter for a present translation
  assign bad = word[0] & (word[1] | word[50] | word[51] | ~MA_OK_MASK[word[4:2]]);

  assign unused_ign = ^word[63:53];
endmodule

// File: rtl/xic_attr_chk.sv
module xic_attr_chk
  import xic_pkg::*;
#(
  parameter logic [63:0] PS_OK_MASK = 64'h0000_0000_1555_7000
) (
  input  logic [WORD_W-1:0] attr,
  input  logic              chk_hi,
  output logic              bad
);
  logic unused_key;

  assign bad = (|attr[1:0]) | ~PS_OK_MASK[attr[7:2]] | (chk_hi & (|attr[63:32]));

  assign unused_key = ^attr[31:8];
endmodule

// File: rtl/xic_va_chk.sv
module xic_va_chk
  import xic_pkg::*;
#(
  parameter int VA_BITS = 51
) (
  input  logic [WORD_W-1:0] va,
  output logic              unimpl
);
  localparam int EXT_W = 61 - VA_BITS;
  logic unused_va;

  generate
    if (EXT_W > 0) begin : g_ext
      assign unimpl = (va[60:VA_BITS] != {EXT_W{va[VA_BITS-1]}});
    end else begin : g_full
      assign unimpl = 1'b0;
    end
  endgenerate

  assign unused_va = ^va;
endmodule

// File: rtl/xlat_insert_checker.sv
module xlat_insert_checker
  import xic_pkg::*;
#(
  parameter bit          CHECK_ON_INSERT = 1'b0,
  parameter int          VA_BITS         = 51,
  parameter logic [63:0] PS_OK_MASK      = 64'h0000_0000_1555_7000,
  parameter logic [7:0]  MA_OK_MASK      = 8'hF1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [1:0]        wr_sel,
  input  logic [VRN_W-1:0]  wr_rgn,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              ins_valid,
  input  logic              ins_dside,
  input  logic [WORD_W-1:0] ins_word,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic              rsp_ins,
  output logic              ent_valid,
  output logic              ent_dside,
  output logic              ent_present,
  output logic              ent_defer,
  output logic [PPN_W-1:0]  ent_ppn,
  output logic [2:0]        ent_rights,
  output logic [1:0]        ent_priv,
  output logic              ent_dirty,
  output logic              ent_acc,
  output logic [2:0]        ent_memattr,
  output logic [5:0]        ent_pgsz,
  output logic [KEY_W-1:0]  ent_pkey,
  output logic [VPN_W-1:0]  ent_vpn,
  output logic [RID_W-1:0]  ent_rid
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // architectural state
  logic [WORD_W-1:0] attr_q, addr_q;
  logic [WORD_W-1:0] rgn_q [NRGN];
  logic              attr_we, addr_we;
  logic [NRGN-1:0]   rgn_we;

  // check results
  logic word_bad, attr_bad_wr, attr_bad_ins, addr_bad_wr, addr_bad_ins, rgn_bad;
  entry_t entry_d, entry_q;
  logic   ent_we, ent_valid_q;
  logic   rsp_v_d, rsp_v_q, rsp_ins_d, rsp_ins_q;
  rsp_code_e rsp_code_d, rsp_code_q, ins_code;

  xic_word_chk #(.MA_OK_MASK(MA_OK_MASK)) u_word (
    .word    (ins_word),
    .bad     (word_bad),
    .present (entry_d.present),
    .defer   (entry_d.defer),
    .ppn     (entry_d.ppn),
    .rights  (entry_d.rights),
    .priv    (entry_d.priv),
    .dirty   (entry_d.dirty),
    .acc     (entry_d.acc),
    .memattr (entry_d.memattr)
  );

  // the parameter places the attribute and address checks
  generate
    if (CHECK_ON_INSERT) begin : g_late
      xic_attr_chk #(.PS_OK_MASK(PS_OK_MASK)) u_attr (
        .attr   (attr_q),
        .chk_hi (ins_word[0]),
        .bad    (attr_bad_ins)
      );
      xic_va_chk #(.VA_BITS(VA_BITS)) u_va (
        .va     (addr_q),
        .unimpl (addr_bad_ins)
      );
      assign attr_bad_wr = 1'b0;
      assign addr_bad_wr = 1'b0;
    end else begin : g_early
      xic_attr_chk #(.PS_OK_MASK(PS_OK_MASK)) u_attr (
        .attr   (wr_data),
        .chk_hi (1'b1),
        .bad    (attr_bad_wr)
      );
      xic_va_chk #(.VA_BITS(VA_BITS)) u_va (
        .va     (wr_data),
        .unimpl (addr_bad_wr)
      );
      assign attr_bad_ins = 1'b0;
      assign addr_bad_ins = 1'b0;
    end
  endgenerate

  assign rgn_bad = wr_data[1] | (|wr_data[63:32]);

  assign entry_d.dside = ins_dside;
  assign entry_d.pgsz  = attr_q[7:2];
  assign entry_d.pkey  = attr_q[31:8];
  assign entry_d.vpn   = addr_q[63:12];
  assign entry_d.rid   = rgn_q[addr_q[63:61]][31:8];

  // next state
  always_comb begin
    rsp_v_d    = 1'b0;
    rsp_ins_d  = 1'b0;
    rsp_code_d = RSP_OK;
    attr_we    = 1'b0;
    addr_we    = 1'b0;
    rgn_we     = '0;
    ent_we     = 1'b0;

    if (word_bad || attr_bad_ins) ins_code = RSP_RSVD;
    else if (addr_bad_ins)        ins_code = RSP_UNIMPL;
    else                          ins_code = RSP_OK;

    if (ins_valid) begin
      rsp_v_d    = 1'b1;
      rsp_ins_d  = 1'b1;
      rsp_code_d = ins_code;
      ent_we     = (ins_code == RSP_OK);
    end else if (wr_valid) begin
      rsp_v_d = 1'b1;
      case (wr_sel_e'(wr_sel))
        SEL_ATTR: if (attr_bad_wr) rsp_code_d = RSP_RSVD;   else attr_we = 1'b1;
        SEL_ADDR: if (addr_bad_wr) rsp_code_d = RSP_UNIMPL; else addr_we = 1'b1;
        SEL_RGN:  if (rgn_bad)     rsp_code_d = RSP_RSVD;   else rgn_we[wr_rgn] = 1'b1;
        default:  rsp_code_d = RSP_OK;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      attr_q <= '0;
      addr_q <= '0;
    end else begin
      if (attr_we) attr_q <= wr_data;
      if (addr_we) addr_q <= wr_data;
    end
  end

  generate
    for (genvar g = 0; g < NRGN; g++) begin : g_rgn
      logic unused_rgn;
      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n)    rgn_q[g] <= '0;
        else if (rgn_we[g]) rgn_q[g] <= wr_data;
      end
      assign unused_rgn = ^{rgn_q[g][63:32], rgn_q[g][7:0]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_v_q     <= 1'b0;
      rsp_ins_q   <= 1'b0;
      rsp_code_q  <= RSP_OK;
      ent_valid_q <= 1'b0;
      entry_q     <= '0;
    end else begin
      rsp_v_q     <= rsp_v_d;
      rsp_ins_q   <= rsp_ins_d;
      rsp_code_q  <= rsp_code_d;
      ent_valid_q <= ent_we;
      if (ent_we) entry_q <= entry_d;
    end
  end

  logic unused_state;
  assign unused_state = ^{attr_q[63:32], attr_q[1:0], addr_q[11:0]};

  assign rsp_valid   = rsp_v_q;
  assign rsp_code    = rsp_code_q;
  assign rsp_ins     = rsp_ins_q;
  assign ent_valid   = ent_valid_q;
  assign ent_dside   = entry_q.dside;
  assign ent_present = entry_q.present;
  assign ent_defer   = entry_q.defer;
  assign ent_ppn     = entry_q.ppn;
  assign ent_rights  = entry_q.rights;
  assign ent_priv    = entry_q.priv;
  assign ent_dirty   = entry_q.dirty;
  assign ent_acc     = entry_q.acc;
  assign ent_memattr = entry_q.memattr;
  assign ent_pgsz    = entry_q.pgsz;
  assign ent_pkey    = entry_q.pkey;
  assign ent_vpn     = entry_q.vpn;
  assign ent_rid     = entry_q.rid;
endmodule

// File: rtl/xic_checker.sv
module xic_checker #(
  parameter bit CHECK_ON_INSERT = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic [1:0]  wr_sel,
  input logic [63:0] wr_data,
  input logic        ins_valid,
  input logic [63:0] ins_word,
  input logic        rsp_valid,
  input logic [1:0]  rsp_code,
  input logic        rsp_ins,
  input logic        ent_valid
);
  p_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid || ins_valid) |=> rsp_valid);

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid || ins_valid) |=> !rsp_valid);

  p_code_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_code != 2'd3));

  p_entry_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> (rsp_valid && rsp_ins && rsp_code == 2'd0));

  p_fault_no_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != 2'd0) |-> !ent_valid);

  p_rgn_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !ins_valid && wr_sel == 2'd2 && (wr_data[1] || (|wr_data[63:32])))
      |=> (rsp_code == 2'd1));

  p_insert_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && ins_valid) |=> rsp_ins);

  generate
    if (!CHECK_ON_INSERT) begin : g_early
      p_absent_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_word[0]) |=> (rsp_code == 2'd0));
      p_no_late_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |=> (rsp_code != 2'd2));
    end
  endgenerate
endmodule

bind xlat_insert_checker xic_checker #(.CHECK_ON_INSERT(CHECK_ON_INSERT)) u_xic_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_valid  (wr_valid),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .ins_valid (ins_valid),
  .ins_word  (ins_word),
  .rsp_valid (rsp_valid),
  .rsp_code  (rsp_code),
  .rsp_ins   (rsp_ins),
  .ent_valid (ent_valid)
);

// File: tb/xlat_insert_checker_tb_top.sv
module xlat_insert_checker_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          VA_BITS    = 51;
  localparam logic [63:0] PS_OK      = 64'h0000_0000_1555_7000;
  localparam logic [7:0]  MA_OK      = 8'hF1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        wr_valid = 1'b0, ins_valid = 1'b0, ins_dside = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [2:0]  wr_rgn = 3'd0;
  logic [63:0] wr_data = '0, ins_word = '0;

  logic        rv0, rv1, ri0, ri1, ev0, ev1;
  logic [1:0]  rc0, rc1;
  logic [156:0] act0, act1;

  logic e0_ds, e0_p, e0_df, e0_d, e0_a; logic [37:0] e0_ppn; logic [2:0] e0_r, e0_m;
  logic [1:0] e0_pl; logic [5:0] e0_ps; logic [23:0] e0_k, e0_rid; logic [51:0] e0_v;
  logic e1_ds, e1_p, e1_df, e1_d, e1_a; logic [37:0] e1_ppn; logic [2:0] e1_r, e1_m;
  logic [1:0] e1_pl; logic [5:0] e1_ps; logic [23:0] e1_k, e1_rid; logic [51:0] e1_v;

  xlat_insert_checker #(.CHECK_ON_INSERT(1'b0), .VA_BITS(VA_BITS),
                        .PS_OK_MASK(PS_OK), .MA_OK_MASK(MA_OK)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_rgn(wr_rgn),
    .wr_data(wr_data), .ins_valid(ins_valid), .ins_dside(ins_dside), .ins_word(ins_word),
    .rsp_valid(rv0), .rsp_code(rc0), .rsp_ins(ri0), .ent_valid(ev0),
    .ent_dside(e0_ds), .ent_present(e0_p), .ent_defer(e0_df), .ent_ppn(e0_ppn),
    .ent_rights(e0_r), .ent_priv(e0_pl), .ent_dirty(e0_d), .ent_acc(e0_a),
    .ent_memattr(e0_m), .ent_pgsz(e0_ps), .ent_pkey(e0_k), .ent_vpn(e0_v), .ent_rid(e0_rid));

  xlat_insert_checker #(.CHECK_ON_INSERT(1'b1), .VA_BITS(VA_BITS),
                        .PS_OK_MASK(PS_OK), .MA_OK_MASK(MA_OK)) dut_late_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_rgn(wr_rgn),
    .wr_data(wr_data), .ins_valid(ins_valid), .ins_dside(ins_dside), .ins_word(ins_word),
    .rsp_valid(rv1), .rsp_code(rc1), .rsp_ins(ri1), .ent_valid(ev1),
    .ent_dside(e1_ds), .ent_present(e1_p), .ent_defer(e1_df), .ent_ppn(e1_ppn),
    .ent_rights(e1_r), .ent_priv(e1_pl), .ent_dirty(e1_d), .ent_acc(e1_a),
    .ent_memattr(e1_m), .ent_pgsz(e1_ps), .ent_pkey(e1_k), .ent_vpn(e1_v), .ent_rid(e1_rid));

  assign act0 = {e0_ds, e0_p, e0_df, e0_ppn, e0_r, e0_pl, e0_d, e0_a, e0_m, e0_ps, e0_k, e0_v, e0_rid};
  assign act1 = {e1_ds, e1_p, e1_df, e1_ppn, e1_r, e1_pl, e1_d, e1_a, e1_m, e1_ps, e1_k, e1_v, e1_rid};

  int n_chk = 0, n_fail = 0;
  logic [159:0] q0[$], q1[$];
  string        t0[$], t1[$];
  logic [63:0]  s_attr[2], s_addr[2];
  logic [63:0]  s_rgn[2][8];
  bit           mon_on = 1'b0;

  function automatic bit unimpl(input logic [63:0] va);
    for (int b = VA_BITS; b <= 60; b++)
      if (va[b] != va[VA_BITS-1]) return 1'b1;
    return 1'b0;
  endfunction

  // reference model: returns {code, is_insert, entry} and updates shadow state
  function automatic logic [159:0] model(input int m, input bit wv, input logic [1:0] sel,
      input logic [2:0] rg, input logic [63:0] wd, input bit iv, input bit ds,
      input logic [63:0] w);
    logic [1:0] code;
    logic [156:0] ent;
    bit rsv, udf, bad;
    logic [63:0] a, f;
    a = s_attr[m];
    f = s_addr[m];
    code = 2'd0;
    ent = '0;
    if (iv) begin
      rsv = w[0] && (w[1] || w[50] || w[51] || !MA_OK[w[4:2]]);
      if (m == 1)
        rsv = rsv || (a[1:0] != 0) || !PS_OK[a[7:2]] || (w[0] && a[63:32] != 0);
      udf = (m == 1) && unimpl(f);
      code = rsv ? 2'd1 : (udf ? 2'd2 : 2'd0);
      ent = {ds, w[0], w[52], w[49:12], w[11:9], w[8:7], w[6], w[5], w[4:2],
             a[7:2], a[31:8], f[63:12], s_rgn[m][f[63:61]][31:8]};
      return {code, 1'b1, ent};
    end
    case (sel)
      2'd0: begin
        bad = (m == 0) && ((wd[1:0] != 0) || (wd[63:32] != 0) || !PS_OK[wd[7:2]]);
        if (bad) code = 2'd1; else s_attr[m] = wd;
      end
      2'd1: begin
        bad = (m == 0) && unimpl(wd);
        if (bad) code = 2'd2; else s_addr[m] = wd;
      end
      2'd2: begin
        bad = wd[1] || (wd[63:32] != 0);
        if (bad) code = 2'd1; else s_rgn[m][rg] = wd;
      end
      default: code = 2'd0;
    endcase
    return {code, 1'b0, ent};
  endfunction

  // driver: presents one request for one cycle and queues the expectations
  task automatic req(input bit wv, input logic [1:0] sel, input logic [2:0] rg,
                     input logic [63:0] wd, input bit iv, input bit ds,
                     input logic [63:0] w, input string tag);
    wr_valid = wv; wr_sel = sel; wr_rgn = rg; wr_data = wd;
    ins_valid = iv; ins_dside = ds; ins_word = w;
    if (wv || iv) begin
      q0.push_back(model(0, wv, sel, rg, wd, iv, ds, w)); t0.push_back(tag);
      q1.push_back(model(1, wv, sel, rg, wd, iv, ds, w)); t1.push_back(tag);
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [2:0] rg, input logic [63:0] d,
                    input string tag);
    req(1'b1, sel, rg, d, 1'b0, 1'b0, '0, tag);
  endtask

  task automatic ins(input bit ds, input logic [63:0] w, input string tag);
    req(1'b0, 2'd0, 3'd0, '0, 1'b1, ds, w, tag);
  endtask

  task automatic idle();
    req(1'b0, 2'd0, 3'd0, '0, 1'b0, 1'b0, '0, "idle");
  endtask

  task automatic compare(input int m, input logic v, input logic [1:0] c, input logic ri,
                         input logic ev, input logic [156:0] act);
    logic [159:0] e;
    string tg;
    if (!v) return;
    n_chk++;
    if ((m == 0 && q0.size() == 0) || (m == 1 && q1.size() == 0)) begin
      n_fail++;
      $display("FAIL R2 mode%0d: response with no request, code=%0d expected none", m, c);
      return;
    end
    if (m == 0) begin e = q0.pop_front(); tg = t0.pop_front(); end
    else        begin e = q1.pop_front(); tg = t1.pop_front(); end
    if (c != e[159:158] || ri != e[157]) begin
      n_fail++;
      $display("FAIL %s mode%0d: code=%0d ins=%0d expected code=%0d ins=%0d",
               tg, m, c, ri, e[159:158], e[157]);
    end else if (e[159:158] == 2'd0 && e[157]) begin
      if (!ev || act != e[156:0]) begin
        n_fail++;
        $display("FAIL %s R5 mode%0d: entry v=%0d %h expected v=1 %h", tg, m, ev, act, e[156:0]);
      end
    end else if (ev) begin
      n_fail++;
      $display("FAIL %s R11 mode%0d: ent_valid=1 expected 0", tg, m);
    end
  endtask

  // monitor: pops and compares as responses appear
  always @(negedge clk) begin
    if (mon_on) begin
      compare(0, rv0, rc0, ri0, ev0, act0);
      compare(1, rv1, rc1, ri1, ev1, act1);
    end
  end

  bit done = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, got no end expected end");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [63:0] mkword(input logic [2:0] ma, input logic [37:0] ppn);
    return (64'h7FF << 53) | (64'd1 << 52) | ({26'd0, ppn} << 12) | (64'd5 << 9) |
           (64'd2 << 7) | (64'd1 << 6) | ({61'd0, ma} << 2) | 64'd1;
  endfunction

  function automatic logic [63:0] mkattr(input logic [23:0] key, input logic [5:0] ps);
    return ({40'd0, key} << 8) | ({58'd0, ps} << 2);
  endfunction

  logic [63:0] lf = 64'h9E37_79B9_7F4A_7C15;
  function automatic logic [63:0] nxt(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    return y ^ (y << 17);
  endfunction

  initial begin
    for (int m = 0; m < 2; m++) begin
      s_attr[m] = '0; s_addr[m] = '0;
      for (int r = 0; r < 8; r++) s_rgn[m][r] = '0;
    end
    repeat (3) @(negedge clk);
    n_chk++;
    if (rv0 || rv1 || ev0 || ev1) begin
      n_fail++;
      $display("FAIL R1: rsp/ent during reset = %b%b%b%b expected 0000", rv0, rv1, ev0, ev1);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_chk++;
    if (rv0 || rv1 || ev0 || ev1) begin
      n_fail++;
      $display("FAIL R1: rsp/ent after reset = %b%b%b%b expected 0000", rv0, rv1, ev0, ev1);
    end
    mon_on = 1'b1;

    // R1: zeroed registers show through the first entry (late copy faults on page size 0)
    ins(1'b0, mkword(3'd0, 38'h1), "R1");
    idle();
    ins(1'b1, 64'h0, "R1_absent");

    // set up legal state
    wr(2'd2, 3'd0, 64'h0000_0000_1234_5634, "R8_ok");
    wr(2'd0, 3'd0, mkattr(24'hABCDE, 6'd14), "R6_ok");
    wr(2'd1, 3'd0, 64'h0000_1234_5678_9000, "R9_ok");
    ins(1'b1, mkword(3'd4, 38'h12345), "R5");
    ins(1'b0, mkword(3'd7, 38'h3F_FFFF_FFFF), "R5_ibuf");

    // R4: reserved translation word bits and encodings
    ins(1'b1, mkword(3'd0, 38'h5) | 64'h2, "R4_bit1");
    ins(1'b1, mkword(3'd0, 38'h5) | (64'd1 << 50), "R4_bit50");
    ins(1'b1, mkword(3'd0, 38'h5) | (64'd1 << 51), "R4_bit51");
    ins(1'b1, mkword(3'd1, 38'h5), "R4_ma");
    // R3: not present waives everything in the word
    ins(1'b1, (mkword(3'd3, 38'h7) | 64'h2 | (64'd3 << 50)) & ~64'd1, "R3");

    // R8 + R11: faulting region writes leave state alone
    wr(2'd2, 3'd0, 64'h0000_0000_00FF_FF02, "R8_bit1");
    wr(2'd2, 3'd0, (64'd1 << 40) | 64'h00AA_AA00, "R8_hi");
    ins(1'b1, mkword(3'd0, 38'h9), "R11_rgn");
    wr(2'd2, 3'd5, 64'h0000_0000_0F0F_0F00, "R8_ok5");
    wr(2'd1, 3'd0, 64'hA000_0000_0000_4000, "R9_ok_vrn5");
    ins(1'b0, mkword(3'd5, 38'h77), "R5_vrn");

    // R6 / R7: attribute checks by mode
    wr(2'd0, 3'd0, mkattr(24'h111, 6'd14) | 64'h1, "R6_low");
    ins(1'b1, mkword(3'd0, 38'h1), "R6_low_ins");
    ins(1'b1, mkword(3'd0, 38'h1) & ~64'd1, "R7_low_still");
    wr(2'd0, 3'd0, mkattr(24'h222, 6'd16) | (64'd1 << 40), "R6_hi");
    ins(1'b1, mkword(3'd0, 38'h2) & ~64'd1, "R7");
    ins(1'b1, mkword(3'd0, 38'h2), "R6_hi_ins");
    wr(2'd0, 3'd0, mkattr(24'h333, 6'd15), "R6_ps");
    ins(1'b1, mkword(3'd0, 38'h3), "R6_ps_ins");
    wr(2'd0, 3'd0, mkattr(24'h444, 6'd12), "R6_ok2");
    ins(1'b1, mkword(3'd0, 38'h4), "R11_attr");

    // R9: address implementation check by mode
    wr(2'd1, 3'd0, 64'h0010_0000_0000_0000, "R9_bad");
    ins(1'b1, mkword(3'd0, 38'h6), "R9_ins");
    ins(1'b1, mkword(3'd0, 38'h6) | 64'h2, "R10");
    wr(2'd1, 3'd0, 64'h1FF8_0000_0000_0000, "R9_badneg");
    wr(2'd1, 3'd0, 64'h1FFC_0000_0000_0000, "R9_okneg");
    ins(1'b1, mkword(3'd0, 38'h8), "R9_okneg_ins");

    // R12: concurrent write is dropped
    req(1'b1, 2'd0, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, mkword(3'd0, 38'hA), "R12");
    ins(1'b1, mkword(3'd0, 38'hB), "R12_after");
    // R2: selector 3 accepted, no effect
    wr(2'd3, 3'd2, 64'hDEAD_BEEF_0000_0000, "R2_none");
    ins(1'b0, mkword(3'd0, 38'hC), "R2_none_after");
    idle();
    idle();

    // mixed pattern sweep
    for (int i = 0; i < 120; i++) begin
      logic [63:0] d;
      lf = nxt(lf);
      d  = nxt(lf);
      if (lf[4]) d = d & 64'h0000_0000_FFFF_FFFC;
      if (lf[5]) d = (d & ~64'hFC) | (64'd14 << 2);
      if (lf[6]) d = d & ~(64'd7 << 50) & ~64'h1C;
      if (lf[7]) d = {d[63:61], {10{d[50]}}, d[50:0]};
      case (lf[2:0])
        3'd0, 3'd1: wr(2'd0, 3'd0, d, "R6_mix");
        3'd2:       wr(2'd1, 3'd0, d, "R9_mix");
        3'd3:       wr(2'd2, lf[10:8], d, "R8_mix");
        3'd4:       req(1'b1, lf[12:11], lf[10:8], d, 1'b1, lf[9], d, "R12_mix");
        default:    ins(lf[9], d, "R10_mix");
      endcase
      if (lf[13]) idle();
    end
    idle();
    idle();
    idle();

    n_chk++;
    if (q0.size() != 0 || q1.size() != 0) begin
      n_fail++;
      $display("FAIL R2: %0d/%0d responses missing expected 0/0", q0.size(), q1.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule